// File: doc/BRIEF.md
# Multiplexed-Bus Register Front End for a Serial Master

This block lets a host processor reach the control and status registers of an SPI master over a byte-wide bus. The bus carries the low address byte and the data on the same lines. On each bus cycle the host first presents the address, marks it valid with an active-low latch strobe, and then raises either a read or a write strobe. A small four-state machine follows this sequence. When the address falls inside the block's window, the machine either stores the data byte or places the selected register on the return lines together with an output enable. The chip pad uses that enable to drive the shared lines and releases them to high impedance when it is low.

The block holds five registers: configuration, slave-select mask, transmit byte, receive byte, and a status byte made of flags. The serial engine lives outside the block. It connects through plain ports. It reports completion, bus activity, contention errors, the hand-off of the transmit byte and the arrival of a received byte. In return it is given the configuration, the slave mask, the transmit byte and the two buffer flags. The block also combines the interrupt causes into a single active-low request line.

Top module: `mbus_regs`

## Requirements
- R1: After reset, all five registers are 0x00 except that the transmit-empty flag is 1. The interrupt line is high and the data output enable is low.
- R2: A cycle begins when the latch strobe `ale_n` is low while `psen_n` is high; at that moment the low address byte is captured from `ad_in`. The transfer happens once a read or write strobe goes low. The cycle ends after the strobe returns high and `ale_n` is released.
- R3: An access matches only when `addr_hi` together with the upper nibble of the captured low byte equals bits 15:4 of `STAT_ADDR` (default 0xC080). A non-matching cycle writes nothing and never enables the data output.
- R4: Low-nibble offsets select the registers: 0x0 status, 0x4 configuration, 0x8 slave mask, 0xA transmit, 0xE receive. Configuration and slave mask read back the value last written. Writes appear on `cfg_ctrl`, `cfg_ss` and `tx_data`.
- R5: During a matched read, `ad_oe` is high and `ad_out` shows the selected register only while `rd_n` is low. `ad_oe` is low at all other times.
- R6: The status byte is {done, error, busy, pending_n, tx_empty, rx_full, 0, 0}, from bit 7 down to bit 0. Done and busy follow `eng_done` and `eng_busy`.
- R7: A host write to the transmit offset clears `tx_empty`. A pulse on `eng_tx_taken` sets it.
- R8: A pulse on `eng_rx_valid` loads `eng_rx_data` into the receive register and sets `rx_full`. A host read of the receive offset clears `rx_full`.
- R9: A pulse on `eng_err_set` sets the error flag. Only a status write with bit 6 equal to 0 clears it; writing 1 leaves it set.
- R10: An interrupt is pending in three cases: error is set, `tx_empty` is set while configuration bit 5 (start) is 1, or `rx_full` is set while start is 0. The pending flag appears inverted in status bit 4. `irq_n` is low only when the flag is pending and configuration bit 6 (interrupt enable) is 1.
- R11: Offsets other than the five in R4 read as 0x00, and writes to them leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 8 | High address byte |
| ad_in | input | 8 | Shared address/data lines, inbound |
| ad_out | output | 8 | Read data toward the pad |
| ad_oe | output | 1 | Pad output enable for the shared lines |
| ale_n | input | 1 | Address latch strobe, active low |
| psen_n | input | 1 | Program-fetch strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| irq_n | output | 1 | Interrupt request, active low |
| eng_done | input | 1 | Engine byte-complete flag |
| eng_busy | input | 1 | Engine slave select active |
| eng_err_set | input | 1 | Pulse: bus contention detected |
| eng_tx_taken | input | 1 | Pulse: transmit byte moved to shifter |
| eng_rx_valid | input | 1 | Pulse: received byte ready |
| eng_rx_data | input | 8 | Received byte |
| cfg_ctrl | output | 8 | Configuration register |
| cfg_ss | output | 8 | Slave-select mask |
| tx_data | output | 8 | Transmit byte |
| tx_empty | output | 1 | Transmit register empty |
| rx_full | output | 1 | Receive register full |

## Verification
The assertions assume that the host follows the bus order. A strobe is raised only while `ale_n` is low, and read and write are never low together. They also assume that the engine pulses last one cycle and never coincide with a host write of the configuration. The bench drives every cycle through two tasks that keep this order. It places engine pulses only between host cycles, so each expected value comes from one cause at a time.

// File: rtl/mbus_regs.sv
module mbus_regs #(
  parameter logic [15:0] STAT_ADDR = 16'hC080
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] addr_hi,
  input  logic [7:0] ad_in,
  output logic [7:0] ad_out,
  output logic       ad_oe,
  input  logic       ale_n,
  input  logic       psen_n,
  input  logic       rd_n,
  input  logic       wr_n,
  output logic       irq_n,
  input  logic       eng_done,
  input  logic       eng_busy,
  input  logic       eng_err_set,
  input  logic       eng_tx_taken,
  input  logic       eng_rx_valid,
  input  logic [7:0] eng_rx_data,
  output logic [7:0] cfg_ctrl,
  output logic [7:0] cfg_ss,
  output logic [7:0] tx_data,
  output logic       tx_empty,
  output logic       rx_full
);
  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_SS   = 4'h8;
  localparam logic [3:0] OFS_TX   = 4'hA;
  localparam logic [3:0] OFS_RX   = 4'hE;

  typedef enum logic [1:0] {S_IDLE, S_DEC, S_XFER, S_END} bus_st_t;
  bus_st_t st;

  logic [7:0] lo_q, ctrl_q, ss_q, tx_q, rx_q;
  logic       rd_cyc_q, err_q, txe_q, rxf_q;

  wire       hit   = {addr_hi, lo_q[7:4]} == STAT_ADDR[15:4];
  wire [3:0] ofs   = lo_q[3:0];
  wire       go    = (st == S_DEC) && hit && (!rd_n || !wr_n);
  wire       wr_go = go && !wr_n;
  wire       rd_go = go && wr_n;
  wire       pend  = err_q | (txe_q & ctrl_q[5]) | (rxf_q & ~ctrl_q[5]);
  wire [7:0] stat  = {eng_done, err_q, eng_busy, ~pend, txe_q, rxf_q, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      lo_q <= '0;
      rd_cyc_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (!ale_n && psen_n) begin
          st <= S_DEC;
          lo_q <= ad_in;
        end
        S_DEC: if (go) begin
          st <= S_XFER;
          rd_cyc_q <= wr_n;
        end else if (ale_n) st <= S_IDLE;
        S_XFER: if (rd_cyc_q ? rd_n : wr_n) st <= S_END;
        S_END: if (ale_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ss_q <= '0;
      tx_q <= '0;
      rx_q <= '0;
      err_q <= 1'b0;
      txe_q <= 1'b1;
      rxf_q <= 1'b0;
    end else begin
      if (wr_go && ofs == OFS_CTRL) ctrl_q <= ad_in;
      if (wr_go && ofs == OFS_SS)   ss_q <= ad_in;
      if (wr_go && ofs == OFS_TX)   tx_q <= ad_in;
      if (eng_rx_valid)             rx_q <= eng_rx_data;
      if (eng_err_set) err_q <= 1'b1;
      else if (wr_go && ofs == OFS_STAT && !ad_in[6]) err_q <= 1'b0;
      if (wr_go && ofs == OFS_TX) txe_q <= 1'b0;
      else if (eng_tx_taken)      txe_q <= 1'b1;
      if (eng_rx_valid) rxf_q <= 1'b1;
      else if (rd_go && ofs == OFS_RX) rxf_q <= 1'b0;
    end
  end

  always_comb begin
    case (ofs)
      OFS_STAT: ad_out = stat;
      OFS_CTRL: ad_out = ctrl_q;
      OFS_SS:   ad_out = ss_q;
      OFS_TX:   ad_out = tx_q;
      OFS_RX:   ad_out = rx_q;
      default:  ad_out = 8'h00;
    endcase
  end

  assign ad_oe    = (st == S_XFER) && rd_cyc_q && !rd_n;
  assign irq_n    = ~(pend & ctrl_q[6]);
  assign cfg_ctrl = ctrl_q;
  assign cfg_ss   = ss_q;
  assign tx_data  = tx_q;
  assign tx_empty = txe_q;
  assign rx_full  = rxf_q;
endmodule

// File: rtl/mbus_regs_chk.sv
module mbus_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       ad_oe,
  input logic       rd_n,
  input logic       ale_n,
  input logic       irq_n,
  input logic [7:0] cfg_ctrl,
  input logic [7:0] tx_data,
  input logic [7:0] ad_in,
  input logic       tx_empty,
  input logic       rx_full,
  input logic [7:0] rx_q,
  input logic [7:0] eng_rx_data,
  input logic       eng_rx_valid,
  input logic       eng_err_set,
  input logic       wr_go,
  input logic       hit,
  input logic [3:0] ofs,
  input logic [1:0] st
);
  // R5
  oe_in_read_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> (!rd_n && !ale_n));
  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> cfg_ctrl[6]);
  // R9
  err_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_err_set && cfg_ctrl[6]) |=> !irq_n);
  // R8
  rx_load_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rx_valid |=> (rx_full && rx_q == $past(eng_rx_data)));
  // R7
  tx_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_go && ofs == 4'hA) |=> (!tx_empty && tx_data == $past(ad_in)));
  // R3
  miss_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && !hit) |=> $stable(cfg_ctrl));
endmodule

bind mbus_regs mbus_regs_chk chk (
  .clk(clk), .rst(rst), .ad_oe(ad_oe), .rd_n(rd_n), .ale_n(ale_n),
  .irq_n(irq_n), .cfg_ctrl(cfg_ctrl), .tx_data(tx_data), .ad_in(ad_in),
  .tx_empty(tx_empty), .rx_full(rx_full), .rx_q(rx_q),
  .eng_rx_data(eng_rx_data), .eng_rx_valid(eng_rx_valid),
  .eng_err_set(eng_err_set), .wr_go(wr_go), .hit(hit), .ofs(ofs), .st(st)
);

// File: tb/mbus_regs_test.sv
module mbus_regs_test;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] addr_hi = '0, ad_in = '0, eng_rx_data = '0;
  logic ale_n = 1'b1, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic eng_done = 1'b0, eng_busy = 1'b0, eng_err_set = 1'b0;
  logic eng_tx_taken = 1'b0, eng_rx_valid = 1'b0;
  logic [7:0] ad_out, cfg_ctrl, cfg_ss, tx_data;
  logic ad_oe, irq_n, tx_empty, rx_full;
  int checks = 0, fails = 0;
  logic [7:0] rd_val;
  logic rd_oe, oe_after;

  always #2 clk = ~clk;

  mbus_regs uut (
    .clk(clk), .rst(rst), .addr_hi(addr_hi), .ad_in(ad_in), .ad_out(ad_out),
    .ad_oe(ad_oe), .ale_n(ale_n), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .irq_n(irq_n), .eng_done(eng_done), .eng_busy(eng_busy),
    .eng_err_set(eng_err_set), .eng_tx_taken(eng_tx_taken),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .cfg_ctrl(cfg_ctrl), .cfg_ss(cfg_ss), .tx_data(tx_data),
    .tx_empty(tx_empty), .rx_full(rx_full)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr_hi = a[15:8]; ad_in = a[7:0]; ale_n = 1'b0; psen_n = 1'b1;
    @(negedge clk); ad_in = d; wr_n = 1'b0;
    @(negedge clk); @(negedge clk); wr_n = 1'b1;
    @(negedge clk); ale_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [15:0] a);
    @(negedge clk); addr_hi = a[15:8]; ad_in = a[7:0]; ale_n = 1'b0; psen_n = 1'b1;
    @(negedge clk); ad_in = 8'hZZ; rd_n = 1'b0;
    @(negedge clk); rd_val = ad_out; rd_oe = ad_oe;
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk); oe_after = ad_oe; ale_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    eng_rx_data = d;
    if (which == 0) eng_tx_taken = 1'b1;
    if (which == 1) eng_rx_valid = 1'b1;
    if (which == 2) eng_err_set = 1'b1;
    @(negedge clk);
    eng_tx_taken = 1'b0; eng_rx_valid = 1'b0; eng_err_set = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got 01 expected 00");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", cfg_ctrl, 8'h00);
    chk("R1 ss", cfg_ss, 8'h00);
    chk("R1 tx", tx_data, 8'h00);
    chk("R1 flags", {5'd0, tx_empty, rx_full, irq_n}, 8'b0000_0101);
    chk("R1 oe", {7'd0, ad_oe}, 8'h00);

    // R4 R2 R5: full configuration sweep, start and enable kept off
    for (int v = 0; v < 256; v++) begin
      bus_wr(16'hC084, 8'(v & 8'h9F));
      chk("R4 cfg port", cfg_ctrl, 8'(v & 8'h9F));
      bus_rd(16'hC084);
      chk("R4 cfg readback", rd_val, 8'(v & 8'h9F));
      chk("R5 oe during read", {7'd0, rd_oe}, 8'h01);
      chk("R5 oe released", {7'd0, oe_after}, 8'h00);
    end
    for (int i = 0; i < 8; i++) begin
      bus_wr(16'hC088, 8'(1 << i));
      bus_rd(16'hC088);
      chk("R4 ss", rd_val, 8'(1 << i));
      chk("R4 ss port", cfg_ss, 8'(1 << i));
    end

    // R3 address mismatch
    bus_wr(16'hC084, 8'h11);
    bus_wr(16'hC184, 8'h22);
    chk("R3 hi miss", cfg_ctrl, 8'h11);
    bus_wr(16'hC094, 8'h33);
    chk("R3 nibble miss", cfg_ctrl, 8'h11);
    bus_rd(16'hC184);
    chk("R3 no drive", {7'd0, rd_oe}, 8'h00);

    // R11 unmapped offsets
    for (int o = 0; o < 16; o++) begin
      if (o != 0 && o != 4 && o != 8 && o != 10 && o != 14) begin
        bus_wr(16'hC080 | 16'(o), 8'hFF);
        bus_rd(16'hC080 | 16'(o));
        chk("R11 reads zero", rd_val, 8'h00);
        chk("R11 no write", cfg_ctrl ^ cfg_ss ^ tx_data, 8'h11 ^ 8'h80 ^ 8'h00);
      end
    end

    // R6 status layout: tx_empty=1, rx_full=0, start=0 -> not pending
    for (int k = 0; k < 4; k++) begin
      eng_done = k[0]; eng_busy = k[1];
      bus_rd(16'hC080);
      chk("R6 status", rd_val, {k[0], 1'b0, k[1], 1'b1, 1'b1, 1'b0, 2'b00});
    end
    eng_done = 1'b0; eng_busy = 1'b0;

    // R10 R7 tx path with start and interrupt enable
    bus_wr(16'hC084, 8'hE0);
    chk("R10 tx empty irq", {7'd0, irq_n}, 8'h00);
    bus_wr(16'hC08A, 8'h5A);
    chk("R7 tx write", {tx_data[7:1], tx_empty}, {7'h2D, 1'b0});
    chk("R10 irq cleared by tx write", {7'd0, irq_n}, 8'h01);
    pulse(0, 8'h00);
    chk("R7 tx taken", {7'd0, tx_empty}, 8'h01);
    chk("R10 irq on empty", {7'd0, irq_n}, 8'h00);
    bus_wr(16'hC08A, 8'hA5);

    // R8 R10 receive path with start off
    bus_wr(16'hC084, 8'hC0);
    chk("R10 idle no irq", {7'd0, irq_n}, 8'h01);
    pulse(1, 8'h3C);
    chk("R8 rx full", {7'd0, rx_full}, 8'h01);
    chk("R10 rx irq", {7'd0, irq_n}, 8'h00);
    bus_rd(16'hC08E);
    chk("R8 rx data", rd_val, 8'h3C);
    chk("R8 rx cleared", {7'd0, rx_full}, 8'h00);
    chk("R10 irq cleared by rx read", {7'd0, irq_n}, 8'h01);

    // R9 error flag
    pulse(2, 8'h00);
    chk("R9 err irq", {7'd0, irq_n}, 8'h00);
    bus_rd(16'hC080);
    chk("R9 status err", rd_val, 8'b0100_0000);
    bus_wr(16'hC080, 8'h40);
    chk("R9 write one keeps", {7'd0, irq_n}, 8'h00);
    bus_wr(16'hC080, 8'h00);
    bus_rd(16'hC080);
    chk("R9 cleared", rd_val, 8'b0001_0000);

    // R10 gating: pending but interrupts disabled
    bus_wr(16'hC084, 8'hA0);
    pulse(0, 8'h00);
    chk("R10 gated off", {7'd0, irq_n}, 8'h01);
    bus_rd(16'hC080);
    chk("R10 pending bit", rd_val, 8'b0000_1000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule